// File: doc/BRIEF.md
# Fault Record Logger

This block keeps a small ring of 128-bit fault records and decides, for each incoming fault report, whether to store it or drop it. Callers hand over a fully formed record as a low quadword and a high quadword, together with the requester's source ID. Two kinds of record share the same ring:

- Address translation faults carry the page-aligned faulting address in the low quadword.
- Interrupt remapping faults carry the 16-bit table index in bits 63:48 of the low quadword.

The logger does not build or interpret either word.

A stored record is placed at the slot named by a next-record pointer. The record's fault flag is raised one cycle after the data lands. Status is updated as follows:

- The first record to become pending sets a pending-fault bit, loads a pending index and sends a one-cycle fault-event pulse.
- Further faults from a source that already has a pending record are collapsed.
- A fault that finds its target slot still occupied sets a sticky overflow bit and is lost.
- While overflow is set, every fault is lost.

Software reads records through a byte-addressed read port and releases them by clearing their fault flags.

Top module: `flog_unit`

## Requirements
- R1: After reset `pend`, `ovf` and `fault_evt` are 0, and every quadword read from the ring is 0.
- R2: Record `i` is read with `rd_addr = i*16` for the low quadword and `i*16+8` for the high quadword. Address bits 2:0 are ignored. Bit 63 of the high quadword reads as the record's fault flag, whatever the caller supplied there; bits 62:0 are the caller's.
- R3: A fault accepted at clock edge k has its data readable after edge k with the fault flag still 0. The flag reads 1 after edge k+1, and any resulting change of `pend`, `pend_idx` and `fault_evt` happens at that same edge.
- R4: After reset the next-record pointer is 0. It advances by one, modulo `NREC`, only for each accepted fault, so slots fill in order 0, 1, …, NREC-1, 0.
- R5: While `ovf` is 1, a new fault is dropped: no slot changes and the pointer stays put.
- R6: If the slot at the pointer still has its fault flag set, the fault is dropped, the pointer stays put and `ovf` becomes 1 at the next edge.
- R7: With `COLLAPSE`=1, a fault is dropped without touching `ovf` or the pointer when its source ID equals that of a record whose flag is set or whose flag is about to be set.
- R8: When `pend` is already 1, a newly flagged record leaves `pend_idx` unchanged and causes no `fault_evt`.
- R9: A one-cycle `rec_clr` with slot `rec_clr_slot` clears that record's fault flag at the next edge. `pend` falls at the edge where no flag remains set. A flag being raised in the same cycle wins over a clear.
- R10: A one-cycle `ovf_clr` clears `ovf` at the next edge, unless a fault sets it in that same cycle.
- R11: When `pend` goes from 0 to 1, `pend_idx` takes the slot just flagged and `fault_evt` is 1 for exactly that one cycle. `fault_evt` is never 1 at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault report strobe, one cycle per report |
| flt_sid | input | SID_W | Source ID of the reporting requester |
| flt_lo | input | 64 | Pre-formed low quadword of the record |
| flt_hi | input | 64 | Pre-formed high quadword (bit 63 replaced by the flag) |
| rec_clr | input | 1 | Write-1-to-clear strobe for one record's fault flag |
| rec_clr_slot | input | IW | Slot whose flag is cleared |
| ovf_clr | input | 1 | Write-1-to-clear strobe for the overflow bit |
| rd_addr | input | AW | Byte address into the record ring |
| rd_data | output | 64 | Quadword at `rd_addr` (combinational) |
| pend | output | 1 | At least one record is pending |
| pend_idx | output | IW | Slot that made `pend` rise |
| ovf | output | 1 | Sticky overflow status |
| fault_evt | output | 1 | One-cycle fault-event request |

## Verification
The hardest situations to reach are the ones where the one-cycle gap between writing data and raising the flag matters.

The first is a second report from the same source that arrives on the very next cycle. It must collapse against a record whose flag is not yet visible. The bench drives two back-to-back reports with equal source IDs to reach this.

The second is overflow caused by a full ring. To get there, the bench fills every slot with distinct sources, never clearing, until the pointer wraps back onto a flagged slot. It then clears that slot and confirms that the sticky overflow still drops the next report, until `ovf_clr` is written.

// File: rtl/flog_pkg.sv
package flog_pkg;
  typedef logic [63:0] qword_t;

  // next ring position, wrapping at n
  function automatic int unsigned ring_next(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // slot number carried by a byte address into the ring
  function automatic int unsigned addr_slot(int unsigned a);
    return a >> 4;
  endfunction
endpackage

// File: rtl/flog_bank.sv
module flog_bank #(
  parameter int NREC  = 4,
  parameter int SID_W = 16,
  parameter int IW    = 2,
  parameter int AW    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_slot,
  input  logic [63:0]           wr_lo,
  input  logic [63:0]           wr_hi,
  input  logic [SID_W-1:0]      wr_sid,
  input  logic                  set_en,
  input  logic [IW-1:0]         set_slot,
  input  logic                  clr_en,
  input  logic [IW-1:0]         clr_slot,
  input  logic [AW-1:0]         rd_addr,
  output logic [63:0]           rd_data,
  output logic [NREC-1:0]       f_vec,
  output logic [NREC*SID_W-1:0] sid_flat
);
  import flog_pkg::*;

  qword_t           lo_q  [NREC];
  qword_t           hi_q  [NREC];
  logic [SID_W-1:0] sid_q [NREC];

  for (genvar i = 0; i < NREC; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        sid_q[i] <= '0;
        f_vec[i] <= 1'b0;
      end else begin
        if (wr_en && wr_slot == IW'(i)) begin
          lo_q[i]  <= wr_lo;
          hi_q[i]  <= wr_hi;
          sid_q[i] <= wr_sid;
        end
        if (set_en && set_slot == IW'(i))      f_vec[i] <= 1'b1;
        else if (clr_en && clr_slot == IW'(i)) f_vec[i] <= 1'b0;
      end
    end
    assign sid_flat[i*SID_W +: SID_W] = sid_q[i];
  end

  always_comb begin
    int unsigned s;
    s = addr_slot(int'(rd_addr));
    rd_data = '0;
    for (int i = 0; i < NREC; i++) begin
      if (s == i) rd_data = rd_addr[3] ? {f_vec[i], hi_q[i][62:0]} : lo_q[i];
    end
  end

  // R3: the flag is raised on the cycle after the data was written into that slot
  p_flag_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> ($past(wr_en) && $past(wr_slot) == set_slot));
  // R9: a clear with no raise on the same slot drops the flag
  p_clear_drops_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_slot == clr_slot)) |=> !f_vec[$past(clr_slot)]);
endmodule

// File: rtl/flog_ctrl.sv
module flog_ctrl #(
  parameter int NREC     = 4,
  parameter int SID_W    = 16,
  parameter int IW       = 2,
  parameter bit COLLAPSE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flt_valid,
  input  logic [SID_W-1:0]      flt_sid,
  input  logic                  clr_en,
  input  logic [IW-1:0]         clr_slot,
  input  logic                  ovf_clr,
  input  logic [NREC-1:0]       f_vec,
  input  logic [NREC*SID_W-1:0] sid_flat,
  output logic                  wr_en,
  output logic [IW-1:0]         wr_slot,
  output logic                  set_en,
  output logic [IW-1:0]         set_slot,
  output logic                  pend,
  output logic [IW-1:0]         pend_idx,
  output logic                  ovf,
  output logic                  evt
);
  import flog_pkg::*;

  logic [IW-1:0]    wr_ptr;
  logic             cm_v;
  logic [IW-1:0]    cm_slot;
  logic [SID_W-1:0] cm_sid;

  // named decision events
  logic [NREC-1:0] sid_hit;
  logic            col_hit;
  logic            full_hit;
  logic            ovf_set;
  logic [NREC-1:0] f_after;
  logic            pend_n;

  for (genvar i = 0; i < NREC; i++) begin : g_match
    assign sid_hit[i] = f_vec[i] && (sid_flat[i*SID_W +: SID_W] == flt_sid);
  end

  assign col_hit  = COLLAPSE && ((|sid_hit) || (cm_v && cm_sid == flt_sid));
  assign full_hit = f_vec[wr_ptr];
  assign wr_en    = flt_valid && !ovf && !col_hit && !full_hit;
  assign ovf_set  = flt_valid && !ovf && !col_hit && full_hit;
  assign wr_slot  = wr_ptr;
  assign set_en   = cm_v;
  assign set_slot = cm_slot;

  always_comb begin
    f_after = f_vec;
    if (clr_en) f_after[clr_slot] = 1'b0;
    if (cm_v)   f_after[cm_slot] = 1'b1;
  end
  assign pend_n = pend ? (|f_after) : cm_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cm_v     <= 1'b0;
      cm_slot  <= '0;
      cm_sid   <= '0;
      pend     <= 1'b0;
      pend_idx <= '0;
      ovf      <= 1'b0;
      evt      <= 1'b0;
    end else begin
      cm_v <= wr_en;
      if (wr_en) begin
        cm_slot <= wr_ptr;
        cm_sid  <= flt_sid;
        wr_ptr  <= IW'(ring_next(int'(wr_ptr), NREC));
      end
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (!pend && cm_v) pend_idx <= cm_slot;
      pend <= pend_n;
      evt  <= pend_n && !pend;
    end
  end

  // R5: nothing is written while overflow is set
  p_no_write_on_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && ovf) |=> $stable(wr_ptr));
  // R6: a report that hits an occupied slot leaves overflow set
  p_full_sets_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf);
  // R4: the pointer moves by one ring step per accepted fault
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ptr == IW'(ring_next(int'($past(wr_ptr)), NREC)));
  // R7: a collapsed report touches neither pointer nor overflow
  p_collapse_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !ovf && col_hit && !ovf_clr) |=> ($stable(wr_ptr) && $stable(ovf)));
  // R8: index holds while pending stays up
  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cm_v) |=> $stable(pend_idx));
  // R11: event is a single-cycle pulse tied to pending rising
  p_evt_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  p_evt_with_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> pend);
endmodule

// File: rtl/flog_unit.sv
module flog_unit #(
  parameter int NREC     = 4,
  parameter int SID_W    = 16,
  parameter bit COLLAPSE = 1'b1,
  localparam int IW      = (NREC > 1) ? $clog2(NREC) : 1,
  localparam int AW      = IW + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_valid,
  input  logic [SID_W-1:0] flt_sid,
  input  logic [63:0]      flt_lo,
  input  logic [63:0]      flt_hi,
  input  logic             rec_clr,
  input  logic [IW-1:0]    rec_clr_slot,
  input  logic             ovf_clr,
  input  logic [AW-1:0]    rd_addr,
  output logic [63:0]      rd_data,
  output logic             pend,
  output logic [IW-1:0]    pend_idx,
  output logic             ovf,
  output logic             fault_evt
);
  logic                  wr_en;
  logic [IW-1:0]         wr_slot;
  logic                  set_en;
  logic [IW-1:0]         set_slot;
  logic [NREC-1:0]       f_vec;
  logic [NREC*SID_W-1:0] sid_flat;

  flog_ctrl #(.NREC(NREC), .SID_W(SID_W), .IW(IW), .COLLAPSE(COLLAPSE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_sid(flt_sid),
    .clr_en(rec_clr), .clr_slot(rec_clr_slot), .ovf_clr(ovf_clr),
    .f_vec(f_vec), .sid_flat(sid_flat), .wr_en(wr_en), .wr_slot(wr_slot),
    .set_en(set_en), .set_slot(set_slot), .pend(pend), .pend_idx(pend_idx),
    .ovf(ovf), .evt(fault_evt)
  );

  flog_bank #(.NREC(NREC), .SID_W(SID_W), .IW(IW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_lo(flt_lo),
    .wr_hi(flt_hi), .wr_sid(flt_sid), .set_en(set_en), .set_slot(set_slot),
    .clr_en(rec_clr), .clr_slot(rec_clr_slot), .rd_addr(rd_addr),
    .rd_data(rd_data), .f_vec(f_vec), .sid_flat(sid_flat)
  );

  // R11: pending never rises without the event
  p_rise_has_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> fault_evt);
endmodule

// File: tb/tb_flog_unit.sv
module tb_flog_unit;
  localparam int NREC = 4;
  localparam int SW   = 16;
  localparam int IW   = 2;
  localparam int AW   = 6;

  logic clk = 0, rst_n = 0;
  logic flt_valid = 0, rec_clr = 0, ovf_clr = 0;
  logic [SW-1:0] flt_sid = '0;
  logic [63:0] flt_lo = '0, flt_hi = '0, rd_data;
  logic [IW-1:0] rec_clr_slot = '0, pend_idx;
  logic [AW-1:0] rd_addr = '0;
  logic pend, ovf, fault_evt;

  always #5 clk = ~clk;

  flog_unit #(.NREC(NREC), .SID_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_sid(flt_sid),
    .flt_lo(flt_lo), .flt_hi(flt_hi), .rec_clr(rec_clr), .rec_clr_slot(rec_clr_slot),
    .ovf_clr(ovf_clr), .rd_addr(rd_addr), .rd_data(rd_data), .pend(pend),
    .pend_idx(pend_idx), .ovf(ovf), .fault_evt(fault_evt)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference: queue of in-flight flag raises, arrays of stored words
  bit          mF   [NREC];
  logic [63:0] mlo  [NREC];
  logic [63:0] mhi  [NREC];
  int          msid [NREC];
  int mptr, midx;
  bit mpend, movf, mevt;
  int raiseq[$];
  int raisesid[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREC; i++) begin mF[i] = 0; mlo[i] = 0; mhi[i] = 0; msid[i] = 0; end
      mptr = 0; midx = 0; mpend = 0; movf = 0; mevt = 0;
      raiseq.delete(); raisesid.delete();
    end else begin
      int flagged; int fsid; bit have; bit hit; bit nov; bit any; bit np;
      have = raiseq.size() > 0;
      flagged = have ? raiseq.pop_front() : -1;
      fsid    = have ? raisesid.pop_front() : -1;
      nov = movf;
      if (ovf_clr) nov = 0;
      if (flt_valid) begin
        hit = (int'(flt_sid) == fsid);
        for (int i = 0; i < NREC; i++) if (mF[i] && msid[i] == int'(flt_sid)) hit = 1;
        if (movf) begin end
        else if (hit) begin end
        else if (mF[mptr]) nov = 1;
        else begin
          mlo[mptr] = flt_lo; mhi[mptr] = flt_hi; msid[mptr] = int'(flt_sid);
          raiseq.push_back(mptr); raisesid.push_back(int'(flt_sid));
          mptr = (mptr + 1) % NREC;
        end
      end
      if (rec_clr) mF[rec_clr_slot] = 0;
      if (have) mF[flagged] = 1;
      any = 0;
      for (int i = 0; i < NREC; i++) any |= mF[i];
      np = mpend ? any : have;
      if (!mpend && have) midx = flagged;
      mevt = np && !mpend;
      mpend = np;
      movf = nov;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison of status outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 pend_idx", 64'(pend_idx), 64'(midx));
      chk("R9 pend", 64'(pend), 64'(mpend));
      chk("R6 ovf", 64'(ovf), 64'(movf));
      chk("R11 fault_evt", 64'(fault_evt), 64'(mevt));
    end
  end

  function automatic logic [63:0] exp_word(int slot, bit hi);
    return hi ? {mF[slot], mhi[slot][62:0]} : mlo[slot];
  endfunction

  task automatic rd(string tag, int slot, bit hi);
    @(negedge clk); #1;
    rd_addr = AW'(slot * 16 + (hi ? 8 : 0) + 3);
    #1 chk(tag, rd_data, exp_word(slot, hi));
  endtask

  task automatic fault(int sid, logic [63:0] lo, logic [63:0] hi);
    @(negedge clk); #2;
    flt_valid = 1; flt_sid = SW'(sid); flt_lo = lo; flt_hi = hi;
    @(negedge clk); #2;
    flt_valid = 0;
  endtask

  task automatic clr(int slot);
    @(negedge clk); #2; rec_clr = 1; rec_clr_slot = IW'(slot);
    @(negedge clk); #2; rec_clr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < NREC; s++) begin
      rd("R1 reset lo", s, 0);
      rd("R1 reset hi", s, 1);
    end
    chk("R1 pend", 64'(pend), 0);

    // first fault: translation-style record, caller sets bit 63 which must be replaced
    @(negedge clk); #2;
    flt_valid = 1; flt_sid = 16'h0011; flt_lo = 64'h0000_1234_5678_9000; flt_hi = 64'hFFFF_0000_8000_0011;
    @(negedge clk); #2; flt_valid = 0;
    rd_addr = AW'(8); #1;
    chk("R3 flag still 0 after data edge", 64'(rd_data[63]), 0);
    chk("R3 data present", 64'(rd_data[62:0]), 64'h7FFF_0000_8000_0011);
    chk("R3 pend not yet", 64'(pend), 0);
    @(negedge clk); #1;
    chk("R3 flag raised", 64'(rd_data[63]), 1);
    chk("R11 evt with flag", 64'(fault_evt), 1);
    rd("R2 slot0 lo", 0, 0);

    // second fault: remapping-style record, index in 63:48
    fault(16'h0022, 64'hABCD_0000_0000_0000, 64'h0000_0000_0022_0022);
    idle(2);
    rd("R2 slot1 lo", 1, 0);
    rd("R8 slot1 hi flagged", 1, 1);

    // R7: repeat from a pending source collapses
    fault(16'h0011, 64'h0000_9999_0000_0000, 64'h1);
    idle(2);
    fault(16'h0033, 64'h0000_0000_3333_3000, 64'h33);
    idle(2);
    rd("R7 R4 next record in slot2", 2, 0);

    // R7: back-to-back same source collapses against in-flight record
    @(negedge clk); #2;
    flt_valid = 1; flt_sid = 16'h0044; flt_lo = 64'h4444_0000; flt_hi = 64'h44;
    @(negedge clk); #2;
    flt_lo = 64'h5555_0000;
    @(negedge clk); #2; flt_valid = 0;
    idle(2);
    rd("R7 in-flight collapse keeps slot3", 3, 0);

    // R6: ring full, pointer wrapped onto flagged slot0
    fault(16'h0055, 64'h5050_0000, 64'h55);
    idle(2);
    chk("R6 ovf set", 64'(ovf), 1);
    rd("R6 slot0 untouched", 0, 0);

    // R5: free slot0, overflow still drops
    clr(0);
    fault(16'h0066, 64'h6060_0000, 64'h66);
    idle(2);
    rd("R5 slot0 not rewritten", 0, 0);
    rd("R9 slot0 flag cleared", 0, 1);

    // R10: clear overflow, then R4 wrap into slot0
    @(negedge clk); #2; ovf_clr = 1;
    @(negedge clk); #2; ovf_clr = 0;
    chk("R10 ovf cleared", 64'(ovf), 0);
    fault(16'h0066, 64'h6060_0000, 64'h66);
    idle(2);
    rd("R4 wrap slot0", 0, 0);

    // R9: release everything, pend falls; R11: new fault raises event at slot1
    for (int s = 0; s < NREC; s++) clr(s);
    idle(2);
    chk("R9 pend cleared", 64'(pend), 0);
    fault(16'h0077, 64'h7070_0000, 64'h77);
    idle(3);
    chk("R11 pend index slot1", 64'(pend_idx), 1);
    rd("R2 slot1 new record", 1, 0);
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule